// File: doc/BRIEF.md
# Prefix Relocation and Storage Key Updater

This block sits just after address translation. It turns a real address into an absolute address by swapping two 8 KiB windows: the window at address zero and the window that starts at the per-CPU prefix. A real address in the low window is moved up by the prefix. A real address in the prefix window is moved down onto absolute page zero. Any other address passes through unchanged. When a block transfer starts inside either window, its length is cut so that it ends at the window edge.

Once the absolute address is known, the block checks it against a memory-size limit and against the span of its key array. An address outside either one returns an addressing exception. An address inside both updates the storage key of its page: the reference bit is set when read permission was granted, and the change bit is set when write permission was granted. Each update goes out on a write port so that the surrounding logic can see the key value just written.

A small state machine runs each request through four states. ST_IDLE accepts a request (transition accept). ST_MAP computes the relocation, the clipped length and the range check. ST_KEY does the read-modify-write of one key. ST_RESP presents the result for one cycle. Leaving ST_MAP takes either to_key or skip_key. Leaving ST_KEY is key_done, and leaving ST_RESP is resp_done.

Top module: `rpk_unit`

## Requirements
- R1: A real address below 8192 gives the absolute address real + prefix. This case wins over R2 when the two windows overlap.
- R2: A real address with prefix <= real < prefix + 8192, and not covered by R1, gives the absolute address real - prefix.
- R3: Every other real address gives an absolute address equal to the real address.
- R4: When the real address is in either window at offset off (real for R1, real - prefix for R2), rsp_len = min(req_len, 8192 - off). Outside both windows, rsp_len = req_len.
- R5: A prefix write stores pfx_wr_data with its low 13 bits forced to zero. The prefix is zero after reset. A request uses the prefix held before the cycle in which it is accepted.
- R6: rsp_addr_exc is 1 when the absolute address is greater than mem_limit, or is at or above NUM_PAGES * 4096. No key write happens in that case.
- R7: For an in-range request with req_rd or req_wr set, exactly one key write is made, to page = absolute address >> 12. key_wr_val is the old key ORed with bit 1 (reference) if req_rd is set and bit 0 (change) if req_wr is set. A request with neither permission writes no key.
- R8: A request is accepted on a clock edge where req_valid and req_ready are both 1. rsp_valid is high for exactly one cycle: 2 cycles after acceptance when no key is written, and 3 cycles after acceptance when a key is written. req_ready is low from acceptance until the response has gone.
- R9: After reset, req_ready = 1, rsp_valid = 0, key_wr_en = 0, and every storage key is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_wr_en | input | 1 | Load the prefix register |
| pfx_wr_data | input | ADDR_W | New prefix value (low 13 bits ignored) |
| mem_limit | input | ADDR_W | Highest valid absolute address, sampled in ST_MAP |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_addr | input | ADDR_W | Real address |
| req_len | input | LEN_W | Requested transfer length in bytes |
| req_rd | input | 1 | Read permission granted |
| req_wr | input | 1 | Write permission granted |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_addr | output | ADDR_W | Absolute address |
| rsp_len | output | LEN_W | Clipped transfer length |
| rsp_addr_exc | output | 1 | Addressing exception |
| key_wr_en | output | 1 | Key write performed this cycle |
| key_wr_page | output | IDX_W | Page index of the key written |
| key_wr_val | output | KEY_W | New key value |

## Verification
The bench tests the edges of both windows: real 8191 and 8192, and prefix + 8191 and prefix + 8192. A design with an off-by-one bound would relocate an address that should pass through, or let one through that should move. Lengths that exactly fill the remaining room, and lengths one byte over it, show up a design that clips at the wrong edge or clips addresses outside the windows. Unaligned prefix writes show up a design that keeps the low bits and so relocates by a wrong amount. Addresses at mem_limit and at mem_limit + 1 catch a range compare of the wrong strictness, or a key write made on an exception. Repeated reads and writes to the same page check that the key bits build up and are never overwritten.

// File: rtl/rpk_pkg.sv
package rpk_pkg;
    localparam int WIN_LSB     = 13;
    localparam int WIN_BYTES   = 1 << WIN_LSB;
    localparam int KEY_W       = 2;
    localparam int KEY_REF_BIT = 1;
    localparam int KEY_CHG_BIT = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAP,
        ST_KEY,
        ST_RESP
    } rpk_state_e;
endpackage

// File: rtl/rpk_prefix_reg.sv
module rpk_prefix_reg
    import rpk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] pfx
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pfx <= '0;
        end else if (wr_en) begin
            // keep the prefix aligned to the window size
            pfx <= {wr_data[ADDR_W-1:WIN_LSB], {WIN_LSB{1'b0}}};
        end
    end
endmodule

// File: rtl/rpk_window_map.sv
module rpk_window_map
    import rpk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] raddr,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] pfx,
    output logic [ADDR_W-1:0] abs_addr,
    output logic [LEN_W-1:0]  len_out
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

    logic              in_low;
    logic              in_pfx;
    logic [ADDR_W-1:0] down;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] room;
    logic [ADDR_W-1:0] len_ext;

    always_comb begin
        down    = raddr - pfx;
        in_low  = (raddr < WIN);
        in_pfx  = !in_low && (raddr >= pfx) && (down < WIN);
        off     = in_low ? raddr : down;
        room    = WIN - off;
        len_ext = ADDR_W'(len);

        if (in_low) begin
            abs_addr = raddr + pfx;
        end else if (in_pfx) begin
            abs_addr = down;
        end else begin
            abs_addr = raddr;
        end

        if ((in_low || in_pfx) && (len_ext > room)) begin
            len_out = LEN_W'(room);
        end else begin
            len_out = len;
        end
    end
endmodule

// File: rtl/rpk_key_store.sv
module rpk_key_store
    import rpk_pkg::*;
#(
    parameter int NUM_PAGES = 64,
    parameter int IDX_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [KEY_W-1:0] set_mask,
    output logic [KEY_W-1:0] new_val
);
    logic [KEY_W-1:0] keys [NUM_PAGES];
    logic [KEY_W-1:0] old_val;

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                keys[g] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                keys[g] <= keys[g] | set_mask;
            end
        end
    end

    always_comb begin
        old_val = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (idx == IDX_W'(i)) begin
                old_val = keys[i];
            end
        end
        new_val = old_val | set_mask;
    end
endmodule

// File: rtl/rpk_unit.sv
module rpk_unit
    import rpk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_PAGES  = 64,
    parameter int IDX_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_wr_en,
    input  logic [ADDR_W-1:0] pfx_wr_data,
    input  logic [ADDR_W-1:0] mem_limit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_rd,
    input  logic              req_wr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LEN_W-1:0]  rsp_len,
    output logic              rsp_addr_exc,
    output logic              key_wr_en,
    output logic [IDX_W-1:0]  key_wr_page,
    output logic [KEY_W-1:0]  key_wr_val
);
    localparam logic [ADDR_W:0] KEY_SPAN = (ADDR_W+1)'(NUM_PAGES) << PAGE_SHIFT;

    rpk_state_e state_q, state_d;

    logic [ADDR_W-1:0] pfx_q;
    logic [ADDR_W-1:0] pfx_snap_q;
    logic [ADDR_W-1:0] raddr_q;
    logic [LEN_W-1:0]  len_q;
    logic              rd_q, wr_q;
    logic [ADDR_W-1:0] abs_q;
    logic [LEN_W-1:0]  rlen_q;
    logic              exc_q;

    logic [ADDR_W-1:0] map_abs;
    logic [LEN_W-1:0]  map_len;
    logic              map_exc;
    logic [KEY_W-1:0]  set_mask;

    rpk_prefix_reg #(.ADDR_W(ADDR_W)) u_pfx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pfx_wr_en),
        .wr_data (pfx_wr_data),
        .pfx     (pfx_q)
    );

    rpk_window_map #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_map (
        .raddr    (raddr_q),
        .len      (len_q),
        .pfx      (pfx_snap_q),
        .abs_addr (map_abs),
        .len_out  (map_len)
    );

    assign map_exc = (map_abs > mem_limit) || ({1'b0, map_abs} >= KEY_SPAN);

    always_comb begin
        set_mask              = '0;
        set_mask[KEY_REF_BIT] = rd_q;
        set_mask[KEY_CHG_BIT] = wr_q;
    end

    rpk_key_store #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (key_wr_en),
        .idx      (key_wr_page),
        .set_mask (set_mask),
        .new_val  (key_wr_val)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_MAP;              // accept
            ST_MAP:  state_d = (!map_exc && (rd_q || wr_q))
                               ? ST_KEY                            // to_key
                               : ST_RESP;                          // skip_key
            ST_KEY:  state_d = ST_RESP;                            // key_done
            ST_RESP: state_d = ST_IDLE;                            // resp_done
            default: state_d = ST_IDLE;
        endcase
    end

    // request capture and mapping results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pfx_snap_q <= '0;
            raddr_q    <= '0;
            len_q      <= '0;
            rd_q       <= 1'b0;
            wr_q       <= 1'b0;
            abs_q      <= '0;
            rlen_q     <= '0;
            exc_q      <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                pfx_snap_q <= pfx_q;
                raddr_q    <= req_addr;
                len_q      <= req_len;
                rd_q       <= req_rd;
                wr_q       <= req_wr;
            end
            if (state_q == ST_MAP) begin
                abs_q  <= map_abs;
                rlen_q <= map_len;
                exc_q  <= map_exc;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        rsp_valid    = (state_q == ST_RESP);
        key_wr_en    = (state_q == ST_KEY);
        key_wr_page  = abs_q[PAGE_SHIFT +: IDX_W];
        rsp_addr     = abs_q;
        rsp_len      = rlen_q;
        rsp_addr_exc = exc_q;
    end
endmodule

// File: rtl/rpk_unit_chk.sv
module rpk_unit_chk
    import rpk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_addr_exc,
    input logic [LEN_W-1:0]  rsp_len,
    input logic [LEN_W-1:0]  len_q,
    input logic [ADDR_W-1:0] pfx_q,
    input logic              key_wr_en,
    input logic [KEY_W-1:0]  key_wr_val
);
    p_pfx_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_q[WIN_LSB-1:0] == '0);

    p_key_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr_en |=> (rsp_valid && !rsp_addr_exc));

    p_key_sets_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr_en |-> (key_wr_val != '0));

    p_rsp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_len <= len_q));
endmodule

bind rpk_unit rpk_unit_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_addr_exc (rsp_addr_exc),
    .rsp_len      (rsp_len),
    .len_q        (len_q),
    .pfx_q        (pfx_q),
    .key_wr_en    (key_wr_en),
    .key_wr_val   (key_wr_val)
);

// File: tb/rpk_unit_bench.sv
module rpk_unit_bench;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int NPG    = 64;
    localparam int IDX_W  = 6;
    localparam longint SPAN = 64 * 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pfx_wr_en = 1'b0;
    logic [ADDR_W-1:0] pfx_wr_data = '0;
    logic [ADDR_W-1:0] mem_limit = 32'd200000;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_rd = 1'b0;
    logic              req_wr = 1'b0;
    logic              rsp_valid;
    logic [ADDR_W-1:0] rsp_addr;
    logic [LEN_W-1:0]  rsp_len;
    logic              rsp_addr_exc;
    logic              key_wr_en;
    logic [IDX_W-1:0]  key_wr_page;
    logic [1:0]        key_wr_val;

    int     n_chk = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    longint m_pfx = 0;
    bit [1:0] km [NPG];

    always #10 clk = ~clk;

    rpk_unit u_rpk_unit (
        .clk(clk), .rst_n(rst_n), .pfx_wr_en(pfx_wr_en), .pfx_wr_data(pfx_wr_data),
        .mem_limit(mem_limit), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_rd(req_rd), .req_wr(req_wr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_len(rsp_len),
        .rsp_addr_exc(rsp_addr_exc), .key_wr_en(key_wr_en),
        .key_wr_page(key_wr_page), .key_wr_val(key_wr_val)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic longint f_abs(longint r, longint p);
        if (r < 8192) return r + p;
        if (r >= p && r < p + 8192) return r - p;
        return r;
    endfunction

    function automatic longint f_len(longint r, longint p, longint l);
        longint off;
        if (r < 8192) off = r;
        else if (r >= p && r < p + 8192) off = r - p;
        else return l;
        return (l > 8192 - off) ? 8192 - off : l;
    endfunction

    task automatic set_pfx(input longint v);
        @(negedge clk);
        pfx_wr_en   = 1'b1;
        pfx_wr_data = ADDR_W'(v);
        @(negedge clk);
        pfx_wr_en = 1'b0;
        m_pfx = v & ~longint'(8191);
    endtask

    task automatic do_req(input longint r, input longint l, input bit rd, input bit wr);
        longint ea, el, pg;
        bit     ex, kexp, kseen, got;
        int     lat, kcnt;
        bit [1:0] kval, ev;
        int     kpg;
        ea = f_abs(r, m_pfx);
        el = f_len(r, m_pfx, l);
        ex = (ea > longint'(mem_limit)) || (ea >= SPAN);
        kexp = !ex && (rd || wr);
        pg = ea >> 12;
        @(negedge clk);
        req_valid = 1'b1; req_addr = ADDR_W'(r); req_len = LEN_W'(l);
        req_rd = rd; req_wr = wr;
        @(negedge clk);
        req_valid = 1'b0;
        got = 1'b0; kseen = 1'b0; kcnt = 0; lat = 0; kval = '0; kpg = 0;
        for (int n = 1; n <= 8; n++) begin
            if (key_wr_en) begin kseen = 1'b1; kcnt++; kval = key_wr_val; kpg = int'(key_wr_page); end
            if (rsp_valid) begin got = 1'b1; lat = n; break; end
            @(negedge clk);
        end
        check(got, "R8 response seen", longint'(got), 1);
        if (!got) return;
        check(lat == (kexp ? 3 : 2), "R8 latency", lat, kexp ? 3 : 2);
        check(rsp_addr_exc == ex, "R6 exception flag", longint'(rsp_addr_exc), longint'(ex));
        check(longint'(rsp_addr) == ea, (r < 8192) ? "R1 low window addr" :
              (r >= m_pfx && r < m_pfx + 8192) ? "R2 prefix window addr" : "R3 pass addr",
              longint'(rsp_addr), ea);
        check(longint'(rsp_len) == el, "R4 clipped length", longint'(rsp_len), el);
        check(kseen == kexp && kcnt <= 1, "R7 key write presence", longint'(kcnt), longint'(kexp));
        if (kexp && kseen) begin
            ev = km[pg] | {rd, wr};
            check(kpg == int'(pg), "R7 key page", kpg, pg);
            check(kval == ev, "R7 key value", longint'(kval), longint'(ev));
            km[pg] = ev;
        end
        @(negedge clk);
        check(!rsp_valid && req_ready, "R8 single-cycle response", longint'(rsp_valid), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NPG; i++) km[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(req_ready && !rsp_valid && !key_wr_en, "R9 reset outputs",
              {req_ready, rsp_valid, key_wr_en}, 3'b100);
        // R5 zero prefix after reset; R9 keys start at zero; R7 accumulate
        do_req(32'h100, 10, 1, 0);
        do_req(32'h100, 10, 0, 1);
        do_req(32'h180, 10, 1, 1);
        // R5 unaligned write masked
        set_pfx(32'h12345);
        do_req(32'h10, 4, 1, 0);                 // R1
        do_req(32'h12010, 4, 0, 1);              // R2
        do_req(8191, 100, 1, 0);                 // R1 edge, R4 clip to 1
        do_req(8192, 100, 1, 0);                 // R3 just past low window
        do_req(32'h12000 + 8191, 5, 1, 0);       // R2 edge, R4 clip
        do_req(32'h12000 + 8192, 5, 1, 0);       // R3 just past prefix window
        do_req(8000, 192, 0, 1);                 // R4 exactly fills room
        do_req(8000, 193, 0, 1);                 // R4 one byte over
        do_req(32'h20000, 9000, 1, 0);           // R3/R4 no clip outside
        do_req(200000, 8, 1, 1);                 // R6 at limit: ok
        do_req(200001, 8, 1, 1);                 // R6 beyond limit
        do_req(32'h30000, 8, 0, 0);              // R7 no permission, no key write
        mem_limit = 32'hFFFF_0000;
        do_req(SPAN, 8, 1, 0);                   // R6 beyond key span
        mem_limit = 32'd200000;
        for (int it = 0; it < 300; it++) begin
            longint r;
            int sel;
            if (it % 30 == 0) set_pfx(longint'($urandom_range(0, 262143)));
            if (it == 150) mem_limit = 32'd230000;
            sel = int'($urandom % 4);
            case (sel)
                0: r = longint'($urandom % 8192);
                1: r = m_pfx + longint'($urandom % 8192);
                2: r = longint'($urandom % 300000);
                default: r = longint'(mem_limit) - 4096 + longint'($urandom % 8192);
            endcase
            do_req(r, longint'($urandom % 20000), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule